// File: doc/BRIEF.md
# Multi-queue interprocessor mailbox controller

This block lets several processors trade short messages through a shared set of hardware queues. It holds `NUM_FIFOS` message queues, each `DEPTH` words deep and `DATA_W` bits wide. It drives one level-high interrupt line for each of `NUM_USERS` users, where a user is one target processor. A processor posts a word by writing a queue's message register. It takes the oldest word out by reading that same register.

Each user line has its own enable mask over an interrupt source matrix. For every queue there are two sources: a receive source, which means a message is waiting, and a transmit source, which means there is room to post. To set up one direction between two processors, enable a queue's receive source on the receiver's line. A sender may also enable the transmit source on its own line, but it does not have to. Posting and draining work the same whether or not that source is enabled.

The register interface is a single-beat request channel. `bus_ready` is always high, so every request is accepted on the cycle that `bus_valid` is high. A read returns its data on `rd_valid`/`rd_data` exactly one cycle later. The read-data path has no back-pressure, so the requester must take the data in that cycle. All registers fit inside a 0x200-byte window.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset, every queue is empty with a count of 0, every overflow flag is 0, every enable mask is 0 and every `irq` bit is low.
- R2: A write to offset 0x040+4·q appends the write data to queue q. A read of that offset removes and returns the oldest word, so words come out in the order they were written. Offset 0x0C0+4·q reads the number of words held in queue q.
- R3: A write to a queue that holds `DEPTH` words is dropped and sets that queue's overflow flag. Offset 0x080+4·q reads bit 0 = full and bit 1 = overflow. Writing 1 to bit 1 of that offset clears the overflow flag.
- R4: A read of an empty queue's message offset returns 0 and leaves the count unchanged.
- R5: The raw source word (user offset +0x0) has bit 2q set while queue q is non-empty (receive) and bit 2q+1 set while queue q is not full (transmit). The word is the same for every user.
- R6: For user u, writing to 0x100+16·u+0x4 sets the enable bits where the data has 1s. Writing to +0x8 clears the enable bits where the data has 1s. Both offsets read back the current mask.
- R7: The masked word at +0xC equals raw AND enable. `irq[u]` is high exactly when user u's masked word is non-zero.
- R8: Writes to read-only locations (raw, masked, count) and to unmapped offsets change no state. Reads of unmapped offsets return 0.
- R9: `bus_ready` is always high. `rd_valid` is high in the cycle after each accepted read, and only then. A write produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset in the 0x200 window |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W | Read data |
| irq | output | NUM_USERS | Per-user interrupt, level high |

## Verification
The bench builds the block with 16 queues and 4 users. With 16 queues the source word uses all 32 bits, so the top transmit bit of the last queue and the full decode range of the queue index are exercised. With 4 users the bench can give each processor a different enable mask. Each mask can then combine receive-only, transmit-only and mixed sources. A depth of 4 lets the random mix of posts and reads often reach both the full and empty boundaries.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Region selectors taken from address bits [8:6]
  localparam logic [2:0] REG_MSG  = 3'b001;  // 0x040
  localparam logic [2:0] REG_FULL = 3'b010;  // 0x080
  localparam logic [2:0] REG_CNT  = 3'b011;  // 0x0C0
  // Per-user interrupt register selectors, address bits [3:2]
  localparam logic [1:0] IRQ_RAW  = 2'd0;
  localparam logic [1:0] IRQ_SET  = 2'd1;
  localparam logic [1:0] IRQ_CLR  = 2'd2;
  localparam logic [1:0] IRQ_MSK  = 2'd3;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic                           pop,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           ovf_clr,
  output logic [DATA_W-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty,
  output logic                           ovf
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full)  ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (ovf && $stable(count)));
  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/mbox_irq_user.sv
module mbox_irq_user #(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] raw,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [SRC_W-1:0] wmask,
  output logic [SRC_W-1:0] en,
  output logic [SRC_W-1:0] masked,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (set_we) en <= en | wmask;
    else if (clr_we) en <= en & ~wmask;
  end

  assign masked = raw & en;
  assign irq    = |masked;

  assert_enable_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en & $past(wmask)) == $past(wmask)));
  assert_enable_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((en & $past(wmask)) == '0));
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we && (wmask == '1)) |=> !irq);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int NUM_FIFOS = 8,
  parameter int NUM_USERS = 4,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [8:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_USERS-1:0] irq
);
  import mbox_pkg::*;

  localparam int SRC_W = 2 * NUM_FIFOS;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             acc_wr, acc_rd;
  logic [2:0]       region;
  logic             is_irq;
  logic [3:0]       fidx, uidx;
  logic [1:0]       rsel;
  logic [SRC_W-1:0] raw;
  logic [DATA_W-1:0] rdata_n;

  logic [DATA_W-1:0] head   [NUM_FIFOS];
  logic [CNT_W-1:0]  cnt    [NUM_FIFOS];
  logic [NUM_FIFOS-1:0] full_v, empty_v, ovf_v;
  logic [SRC_W-1:0]  en_v   [NUM_USERS];
  logic [SRC_W-1:0]  msk_v  [NUM_USERS];

  logic unused_addr_bits;
  assign unused_addr_bits = ^bus_addr[1:0];

  assign bus_ready = 1'b1;
  assign acc_wr    = bus_valid & bus_write;
  assign acc_rd    = bus_valid & ~bus_write;
  assign region    = bus_addr[8:6];
  assign is_irq    = bus_addr[8];
  assign fidx      = bus_addr[5:2];
  assign uidx      = bus_addr[7:4];
  assign rsel      = bus_addr[3:2];

  for (genvar f = 0; f < NUM_FIFOS; f++) begin : g_fifo
    logic sel;
    assign sel = !is_irq && (fidx == 4'(f));
    mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (acc_wr && sel && region == REG_MSG),
      .pop     (acc_rd && sel && region == REG_MSG),
      .wdata   (bus_wdata),
      .ovf_clr (acc_wr && sel && region == REG_FULL && bus_wdata[1]),
      .head    (head[f]),
      .count   (cnt[f]),
      .full    (full_v[f]),
      .empty   (empty_v[f]),
      .ovf     (ovf_v[f])
    );
    assign raw[2*f]   = ~empty_v[f];
    assign raw[2*f+1] = ~full_v[f];
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic sel;
    assign sel = is_irq && (uidx == 4'(u));
    mbox_irq_user #(.SRC_W(SRC_W)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw),
      .set_we (acc_wr && sel && rsel == IRQ_SET),
      .clr_we (acc_wr && sel && rsel == IRQ_CLR),
      .wmask  (bus_wdata[SRC_W-1:0]),
      .en     (en_v[u]),
      .masked (msk_v[u]),
      .irq    (irq[u])
    );
  end

  always_comb begin
    rdata_n = '0;
    if (is_irq) begin
      for (int u = 0; u < NUM_USERS; u++) begin
        if (uidx == 4'(u)) begin
          case (rsel)
            IRQ_RAW:          rdata_n = DATA_W'(raw);
            IRQ_SET, IRQ_CLR: rdata_n = DATA_W'(en_v[u]);
            default:          rdata_n = DATA_W'(msk_v[u]);
          endcase
        end
      end
    end else begin
      for (int f = 0; f < NUM_FIFOS; f++) begin
        if (fidx == 4'(f)) begin
          case (region)
            REG_MSG:  rdata_n = empty_v[f] ? '0 : head[f];
            REG_FULL: rdata_n = DATA_W'({ovf_v[f], full_v[f]});
            REG_CNT:  rdata_n = DATA_W'(cnt[f]);
            default:  rdata_n = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_rd;
      rd_data  <= acc_rd ? rdata_n : '0;
    end
  end

  assert_read_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> rd_valid);
  assert_write_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !rd_valid);
  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready);
endmodule

// File: tb/mbox_ctrl_tb.sv
module mbox_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 16;
  localparam int NU = 4;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rd_valid;
  logic [31:0] rd_data;
  logic [NU-1:0] irq;

  int checks = 0, fails = 0;
  logic [31:0] mq [NF][$];
  logic [NF-1:0] ovf_m = '0;
  logic [31:0] en_m [NU];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_ctrl #(.NUM_FIFOS(NF), .NUM_USERS(NU), .DEPTH(DP), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq));

  function automatic logic [31:0] exp_raw();
    logic [31:0] r = '0;
    for (int f = 0; f < NF; f++) begin
      r[2*f]   = (mq[f].size() != 0);
      r[2*f+1] = (mq[f].size() != DP);
    end
    return r;
  endfunction

  function automatic logic [NU-1:0] exp_irq();
    logic [NU-1:0] v;
    for (int u = 0; u < NU; u++) v[u] = |(exp_raw() & en_m[u]);
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R9 no read response after write", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    check("R9 ready", {31'd0, bus_ready}, 32'd1);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R9 rd_valid one cycle after read", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  // Model-tracked operations
  task automatic post(int f, logic [31:0] d);
    wr(9'h040 + 9'(4*f), d);
    if (mq[f].size() == DP) ovf_m[f] = 1'b1;
    else mq[f].push_back(d);
  endtask

  task automatic take(int f, string req);
    logic [31:0] d, e;
    rd(9'h040 + 9'(4*f), d);
    e = (mq[f].size() != 0) ? mq[f].pop_front() : 32'd0;
    check(req, d, e);
  endtask

  task automatic check_irq(string req);
    check(req, 32'(irq), 32'(exp_irq()));
  endtask

  task automatic check_status(int f);
    logic [31:0] d;
    rd(9'h080 + 9'(4*f), d);
    check("R3 full/overflow flags", d, {30'd0, ovf_m[f], mq[f].size() == DP});
    rd(9'h0C0 + 9'(4*f), d);
    check("R2 count field", d, 32'(mq[f].size()));
  endtask

  initial begin
    logic [31:0] d;
    for (int u = 0; u < NU; u++) en_m[u] = '0;
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check("R1 irq low", 32'(irq), 32'd0);
    rd(9'h0C0, d);               check("R1 count zero", d, 32'd0);
    rd(9'h100, d);               check("R5 raw after reset", d, 32'hAAAA_AAAA);
    rd(9'h114, d);               check("R1 enable zero", d, 32'd0);
    rd(9'h080 + 9'(4*15), d);    check("R1 no overflow", d, 32'd0);

    // R2/R3 fill queue 3 past full
    for (int i = 0; i < DP + 1; i++) post(3, 32'hC0DE_0000 + 32'(i));
    check_status(3);
    rd(9'h100, d);               check("R5 full queue drops tx bit", d, exp_raw());
    for (int i = 0; i < DP; i++) take(3, "R2 in-order dequeue");
    take(3, "R4 empty read returns zero");
    check_status(3);
    wr(9'h080 + 9'(4*3), 32'h2); ovf_m[3] = 1'b0;
    check_status(3);

    // R7 receive-only on user 1, transmit-only on user 0 for queue 15
    wr(9'h114, 32'h4000_0000); en_m[1] = 32'h4000_0000;
    check_irq("R7 rx source idle");
    post(15, 32'h1234_5678);
    check_irq("R7 rx source pending");
    wr(9'h104, 32'h8000_0000); en_m[0] = 32'h8000_0000;
    check_irq("R7 tx source space");
    rd(9'h11C, d);               check("R7 masked word", d, exp_raw() & en_m[1]);
    wr(9'h108, 32'hFFFF_FFFF); en_m[0] = '0;
    rd(9'h104, d);               check("R6 cleared mask", d, 32'd0);

    // R8 writes to read-only/unmapped spots
    wr(9'h100, 32'hFFFF_FFFF);
    wr(9'h10C, 32'hFFFF_FFFF);
    wr(9'h0C0 + 9'(4*15), 32'h7);
    wr(9'h000, 32'hFFFF_FFFF);
    wr(9'h1F4, 32'hFFFF_FFFF);
    rd(9'h100, d);               check("R8 raw unchanged", d, exp_raw());
    check_status(15);
    rd(9'h118, d);               check("R8 user1 mask unchanged", d, en_m[1]);
    rd(9'h000, d);               check("R8 unmapped read zero", d, 32'd0);
    check_irq("R8 irq unchanged");
    take(15, "R2 single message");

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int op = int'($urandom % 9);
      int f  = int'($urandom % NF);
      int u  = int'($urandom % NU);
      logic [31:0] m = $urandom;
      case (op)
        0, 1, 2: post(f % 4, m);
        3, 4:    take(f % 4, "R2 random dequeue");
        5: begin wr(9'h104 + 9'(16*u), m); en_m[u] |= m; end
        6: begin wr(9'h108 + 9'(16*u), m); en_m[u] &= ~m; end
        7: begin
          check_status(f % 4);
          rd(9'h10C + 9'(16*u), d); check("R7 random masked", d, exp_raw() & en_m[u]);
          rd(9'h108 + 9'(16*u), d); check("R6 random mask", d, en_m[u]);
        end
        default: begin
          wr(9'h080 + 9'(4*(f % 4)), 32'h2); ovf_m[f % 4] = 1'b0;
          rd(9'h100, d); check("R5 random raw", d, exp_raw());
        end
      endcase
      check_irq("R7 random irq");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule